// File: doc/BRIEF.md
# Shift-Add Sequential Unsigned Multiplier

This block forms the product of two unsigned operands one multiplier bit at a time. A start pulse loads the multiplier into the low half of a double-width accumulator, which has one extra bit at the top. The same pulse clears the upper bits of the accumulator, captures the multiplicand and clears a step counter. Each step then looks at the least significant accumulator bit. When that bit is one, the multiplicand is added into the upper accumulator bits, with the carry kept in the extra top bit, and a right shift of the whole accumulator follows. When that bit is zero, only the shift is done.

The step counter is a separate unit from the add/shift controller. When the final shift of the operand width has been taken, the counter raises its completion signal and the controller stops. The product is the low double-width part of the accumulator. The done flag stays high until the next accepted start. A start that arrives while a multiplication is running is ignored. The operand width is a parameter, and the default is 4 bits.

Top module: `shiftadd_mul`

## Requirements
- R1: While reset is applied and after it is released, `done` is 0 and `product` is 0 until the first accepted start.
- R2: A start seen in the idle or done state is accepted. It captures both operands, and `done` reads 0 in the cycle after the accepting edge.
- R3: A multiplier bit of 0 takes one clock and a bit of 1 takes two clocks (an add, then a shift). `done` therefore first reads 1 after W + ones(mplier) + 1 rising edges, counting the edge that accepted start.
- R4: While `done` is 1, `product` equals mplier × mcand for the operands captured at the accepted start, taken as unsigned and 2W bits wide.
- R5: While `start` is low, `done` stays at 1 and `product` stays unchanged, even when the operand inputs change.
- R6: A start pulse seen while a multiplication is running has no effect. The latency and the result are those of the running operation.
- R7: A zero multiplier or a zero multiplicand gives a product of 0.
- R8: All-ones operands give (2^W−1)², which is 225 for W=4. The carry out of the adder is never lost.
- R9: In the controller, every add step is followed on the next clock by a shift step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; released synchronously inside the block |
| start | input | 1 | One-cycle request to begin a multiplication |
| mplier | input | W | Unsigned multiplier, sampled on the accepted start |
| mcand | input | W | Unsigned multiplicand, sampled on the accepted start |
| product | output | 2W | Unsigned product, valid while done is 1 |
| done | output | 1 | High from the end of a multiplication until the next accepted start |

## Verification
The latency depends on the data. `done` is due W + ones(mplier) + 1 rising edges after the edge that accepts start. It falls one edge after a new start is accepted, and the product is valid in the same cycle that `done` rises. The bench keeps a behavioural model with a countdown that is loaded with that number at each accepted start. Both `done` and `product` are compared with it on every falling edge, which lies half a period after each register update. The directed checks count falling edges from the start pulse to the rise of `done` and compare that count against the same formula. The checks cover every operand pair, and also a start pulse placed in the middle of a running operation.

// File: rtl/mul_pkg.sv
package mul_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_TEST  = 2'd1,
    ST_SHIFT = 2'd2,
    ST_DONE  = 2'd3
  } mul_state_e;
endpackage

// File: rtl/mul_step_counter.sv
module mul_step_counter #(
  parameter int W = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic last
);
  localparam int CW = (W > 2) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST_CNT = CW'(W - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = clr | inc;
    cnt_d  = clr ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign last = (cnt_q == LAST_CNT);
endmodule

// File: rtl/mul_ctrl.sv
module mul_ctrl
  import mul_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic lsb,
  input  logic last,
  output logic ld,
  output logic ad,
  output logic sh,
  output logic busy,
  output logic done
);
  mul_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    ld   = 1'b0;
    ad   = 1'b0;
    sh   = 1'b0;
    unique case (st_q)
      ST_IDLE, ST_DONE: begin
        if (start) begin
          ld   = 1'b1;
          st_d = ST_TEST;
        end
      end
      ST_TEST: begin
        if (lsb) begin
          ad   = 1'b1;
          st_d = ST_SHIFT;
        end else begin
          sh   = 1'b1;
          st_d = last ? ST_DONE : ST_TEST;
        end
      end
      ST_SHIFT: begin
        sh   = 1'b1;
        st_d = last ? ST_DONE : ST_TEST;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assign busy = (st_q == ST_TEST) || (st_q == ST_SHIFT);
  assign done = (st_q == ST_DONE);
endmodule

// File: rtl/mul_datapath.sv
module mul_datapath #(
  parameter int W = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ld,
  input  logic           ad,
  input  logic           sh,
  input  logic [W-1:0]   mplier_i,
  input  logic [W-1:0]   mcand_i,
  output logic           lsb,
  output logic [2*W-1:0] prod
);
  localparam int AW = 2 * W + 1;

  logic [AW-1:0] acc_q, acc_d;
  logic          acc_en;
  logic [W-1:0]  mc_q;
  logic [W:0]    sum;

  always_comb begin
    sum    = {1'b0, acc_q[AW-2:W]} + {1'b0, mc_q};
    acc_en = ld | ad | sh;
    if (ld)      acc_d = {{(W+1){1'b0}}, mplier_i};
    else if (ad) acc_d = {sum, acc_q[W-1:0]};
    else         acc_d = {1'b0, acc_q[AW-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc_q <= '0;
    else if (acc_en) acc_q <= acc_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  mc_q <= '0;
    else if (ld) mc_q <= mcand_i;
  end

  assign lsb  = acc_q[0];
  assign prod = acc_q[2*W-1:0];
endmodule

// File: rtl/shiftadd_mul.sv
module shiftadd_mul #(
  parameter int W = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [W-1:0]   mplier,
  input  logic [W-1:0]   mcand,
  output logic [2*W-1:0] product,
  output logic           done
);
  logic [1:0] rsync_q;
  logic       rst_int_n;
  logic       ld, ad, sh, busy, lsb, last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_int_n = rsync_q[1];

  mul_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_int_n), .start(start), .lsb(lsb), .last(last),
    .ld(ld), .ad(ad), .sh(sh), .busy(busy), .done(done)
  );

  mul_step_counter #(.W(W)) u_cnt (
    .clk(clk), .rst_n(rst_int_n), .clr(ld), .inc(sh), .last(last)
  );

  mul_datapath #(.W(W)) u_dp (
    .clk(clk), .rst_n(rst_int_n), .ld(ld), .ad(ad), .sh(sh),
    .mplier_i(mplier), .mcand_i(mcand), .lsb(lsb), .prod(product)
  );
endmodule

// File: rtl/mul_checker.sv
module mul_checker #(
  parameter int W = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start,
  input logic [W-1:0]   mplier,
  input logic [W-1:0]   mcand,
  input logic [2*W-1:0] product,
  input logic           done,
  input logic           ld,
  input logic           ad,
  input logic           sh,
  input logic           busy
);
  logic [W-1:0]   cap_a, cap_b;
  logic [2*W-1:0] exp_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_a <= '0;
      cap_b <= '0;
    end else if (ld) begin
      cap_a <= mplier;
      cap_b <= mcand;
    end
  end
  assign exp_p = {{W{1'b0}}, cap_a} * {{W{1'b0}}, cap_b};

  a_r4_product_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> product == exp_p);

  a_r5_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(product)));

  a_r2_start_drops_done: assert property (@(posedge clk) disable iff (!rst_n)
    (done && start) |=> !done);

  a_r6_busy_no_load: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !ld);

  a_r9_add_then_shift: assert property (@(posedge clk) disable iff (!rst_n)
    ad |=> sh);

  a_r3_single_action: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ld, ad, sh}));
endmodule

bind shiftadd_mul mul_checker #(.W(W)) u_mul_chk (
  .clk(clk), .rst_n(rst_int_n), .start(start), .mplier(mplier),
  .mcand(mcand), .product(product), .done(done), .ld(ld), .ad(ad),
  .sh(sh), .busy(busy)
);

// File: tb/test_shiftadd_mul.sv
module test_shiftadd_mul;
  localparam int W = 4;
  localparam int PW = 2 * W;
  localparam time CLK_PERIOD = 10ns;

  logic          clk;
  logic          rst_n;
  logic          start;
  logic [W-1:0]  mplier, mcand;
  logic [PW-1:0] product;
  logic          done;

  int checks;
  int fails;

  // behavioural reference
  int  m_left;
  bit  m_busy;
  bit  m_done;
  int  m_prod;

  shiftadd_mul #(.W(W)) i_shiftadd_mul (
    .clk(clk), .rst_n(rst_n), .start(start), .mplier(mplier),
    .mcand(mcand), .product(product), .done(done)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_prod = 0; m_left = 0;
    end else if (start && !m_busy) begin
      m_busy = 1; m_done = 0;
      m_left = W + $countones(mplier);
      m_prod = int'(mplier) * int'(mcand);
    end else if (m_busy) begin
      m_left = m_left - 1;
      if (m_left == 0) begin
        m_busy = 0; m_done = 1;
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // cycle-by-cycle comparison against the model (R1 R4 R5)
  always @(negedge clk) begin
    if (rst_n) begin
      check("R5 done vs model", int'(done), int'(m_done));
      if (m_done || (!m_busy && !m_done))
        check("R4 product vs model", int'(product), m_prod);
    end
  end

  task automatic pulse(input logic [W-1:0] a, input logic [W-1:0] b);
    @(negedge clk);
    start = 1'b1; mplier = a; mcand = b;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output int cyc);
    cyc = 1;
    while (!done && cyc < 100) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic run(input logic [W-1:0] a, input logic [W-1:0] b, input string req);
    int cyc;
    pulse(a, b);
    check("R2 done low after start", int'(done), 0);
    wait_done(cyc);
    check("R3 latency", cyc, 1 + W + $countones(a));
    check(req, int'(product), int'(a) * int'(b));
  endtask

  initial begin
    int cyc;
    checks = 0; fails = 0;
    start = 1'b0; mplier = '0; mcand = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset done", int'(done), 0);
    check("R1 reset product", int'(product), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 idle done", int'(done), 0);
    check("R1 idle product", int'(product), 0);

    run(4'd0, 4'd13, "R7 zero multiplier");
    run(4'd11, 4'd0, "R7 zero multiplicand");
    run(4'd15, 4'd15, "R8 all ones");
    run(4'd5, 4'd9, "R4 mixed pattern");

    // R5: hold with operand inputs changing
    mplier = 4'd3; mcand = 4'd7;
    repeat (3) begin
      @(negedge clk);
      check("R5 done held", int'(done), 1);
      check("R5 product held", int'(product), 45);
    end

    // R6: start in mid-operation is ignored
    pulse(4'd6, 4'd7);
    @(negedge clk);
    start = 1'b1; mplier = 4'd15; mcand = 4'd15;
    @(negedge clk);
    start = 1'b0;
    wait_done(cyc);
    check("R6 latency unchanged", cyc + 2, 1 + W + $countones(4'd6));
    check("R6 result unchanged", int'(product), 42);

    // R4 exhaustive sweep
    for (int a = 0; a < (1 << W); a++)
      for (int b = 0; b < (1 << W); b++)
        run(W'(a), W'(b), "R4 exhaustive");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule